// File: doc/BRIEF.md
# Row-Based Program Flash Controller

This block sits between a processor's register-style host port and an on-chip program flash array of 14-bit words grouped into 32-word rows. The host sets an address register and then issues single-word reads or latch loads. Programming is staged: the host fills a row-sized set of hidden write latches one word at a time and then commits them to a row. The host can also erase one row. Erase and write run for a fixed number of cycles counted by an internal timer. A busy level covers that time, and a one-cycle done pulse marks the end of every accepted command.

A second port serves an external programmer. It can read or program single words, bulk-erase the whole array, and program the configuration bits. These bits select the write-protected region for self-programming and turn on code protection. Programming can only clear bits, so a commit stores the old word ANDed with the new data, and only an erase returns bits to one. The two protection schemes are independent. Write protection refuses self erase and self write on a region of the array. Code protection refuses programmer reads and writes. Only a programmer bulk erase removes code protection.

Top module: `flash_row_ctrl`

## Requirements
- R1: After reset, busy, done and err are 0, rdata is 0, no region is write-protected, code protection is off, and every write latch holds 3FFF.
- R2: Host op 0 loads the address register from cmd_addr. Host op 1 reads the word at the address register. For both, done is high and rdata (for the read) is valid in the cycle after acceptance, and busy stays low.
- R3: Host op 2 stores cmd_wdata into the latch selected by the low 5 bits of the address register, then increments those 5 bits modulo 32 and leaves the row bits unchanged.
- R4: Host op 4 commits the latches to the row of the address register, with each word becoming old AND latch. After the commit every latch returns to 3FFF, so unloaded positions leave their words unchanged.
- R5: Host op 3 sets all 32 words of the addressed row to 3FFF and touches no other row.
- R6: Row erase and programmer bulk erase hold busy for ERASE_CYC cycles. Row write and programmer word write hold busy for WRITE_CYC cycles. Done is high for exactly the one cycle in which busy has just fallen.
- R7: While busy, commands on both ports are ignored: they have no effect on memory, the address register or rdata.
- R8: The write-protect setting maps 11 to none, 10 to words below BOOT_WORDS, 01 to the lower half and 00 to the whole array. A host row erase or row write on a protected row is refused: done pulses, err is set and memory is unchanged. Programmer writes are never affected.
- R9: Host op 5 (bulk erase) and the unused host ops 6 and 7 are always refused with err set and memory unchanged.
- R10: With code protection on, programmer op 0 (read), op 1 (word write, old AND data) and op 3 (configuration) are refused with err set, and rdata and memory are unchanged. Host erase and write still work.
- R11: Programmer op 2 (bulk erase) is always accepted. It sets every word to 3FFF, returns write protection to 11 and turns code protection off.
- R12: Programmer op 3 ANDs prg_wdata[1:0] into the write-protect setting, and prg_wdata[2]=0 turns code protection on. When both ports are valid in an idle cycle, the programmer command is taken and the host command is dropped.
- R13: Every accepted command clears err, and err is set only together with a done pulse for a refused command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Host op: 0 set address, 1 read, 2 load latch, 3 row erase, 4 row write, 5 bulk erase |
| cmd_addr | input | AW | Host address for op 0 |
| cmd_wdata | input | WORD_W | Host latch data for op 2 |
| prg_valid | input | 1 | Programmer command strobe |
| prg_op | input | 2 | Programmer op: 0 read, 1 word write, 2 bulk erase, 3 configuration |
| prg_addr | input | AW | Programmer word address |
| prg_wdata | input | WORD_W | Programmer write data or configuration bits |
| busy | output | 1 | A timed operation is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last accepted command was refused |
| rdata | output | WORD_W | Last word read |

## Verification
The assertions assume that the timing parameters are at least one. They also assume that a command strobe lasts exactly one cycle, so that the cycle after an accepted command shows that command's result and not a new one. The stimulus holds each strobe for a single cycle. It waits for done before the next command, except in two places where it deliberately issues commands while busy or on both ports at once. Memory contents are checked across the whole array against an arithmetic model after each phase, under every write-protect encoding.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [2:0] {
        H_SETADDR = 3'd0,
        H_READ    = 3'd1,
        H_LOAD    = 3'd2,
        H_ERASE   = 3'd3,
        H_WRITE   = 3'd4,
        H_BULK    = 3'd5,
        H_RSV6    = 3'd6,
        H_RSV7    = 3'd7
    } host_op_e;

    typedef enum logic [1:0] {
        P_READ  = 2'd0,
        P_WRITE = 2'd1,
        P_BULK  = 2'd2,
        P_CFG   = 2'd3
    } prog_op_e;

    typedef enum logic [1:0] {
        J_ERASE_ROW = 2'd0,
        J_WRITE_ROW = 2'd1,
        J_PROG_WORD = 2'd2,
        J_BULK      = 2'd3
    } job_e;

endpackage

// File: rtl/flash_wp_check.sv
module flash_wp_check #(
    parameter int AW         = 11,
    parameter int NUM_WORDS  = 2048,
    parameter int BOOT_WORDS = 512
) (
    input  logic [1:0]    wrt,
    input  logic [AW-1:0] addr,
    output logic          blocked
);
    localparam int LW = AW + 1;

    logic [LW-1:0] limit;

    always_comb begin
        unique case (wrt)
            2'b11:   limit = '0;
            2'b10:   limit = LW'(BOOT_WORDS);
            2'b01:   limit = LW'(NUM_WORDS / 2);
            default: limit = LW'(NUM_WORDS);
        endcase
        blocked = ({1'b0, addr} < limit);
    end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] len,
    output logic          run,
    output logic          expired
);
    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = len - TW'(1);
        end else if (t_q.run) begin
            if (t_q.cnt == '0) t_d.run = 1'b0;
            else               t_d.cnt = t_q.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign run     = t_q.run;
    assign expired = t_q.run && (t_q.cnt == '0);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int WORD_W    = 14,
    parameter int ROW_WORDS = 32,
    parameter int NUM_WORDS = 2048
) (
    input  logic                              clk,
    input  logic [$clog2(NUM_WORDS)-1:0]      rd_addr,
    output logic [WORD_W-1:0]                 rd_data,
    input  logic                              bulk_erase,
    input  logic                              row_erase,
    input  logic                              row_prog,
    input  logic [$clog2(NUM_WORDS)-$clog2(ROW_WORDS)-1:0] row_sel,
    input  logic [ROW_WORDS-1:0][WORD_W-1:0]  row_data,
    input  logic                              word_prog,
    input  logic [$clog2(NUM_WORDS)-1:0]      word_addr,
    input  logic [WORD_W-1:0]                 word_data
);
    localparam int CW = $clog2(ROW_WORDS);

    logic [WORD_W-1:0] mem [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (bulk_erase) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '1;
        end else if (row_erase) begin
            for (int i = 0; i < ROW_WORDS; i++) mem[{row_sel, CW'(i)}] <= '1;
        end else if (row_prog) begin
            for (int i = 0; i < ROW_WORDS; i++)
                mem[{row_sel, CW'(i)}] <= mem[{row_sel, CW'(i)}] & row_data[i];
        end else if (word_prog) begin
            mem[word_addr] <= mem[word_addr] & word_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_row_ctrl.sv
module flash_row_ctrl
    import flash_pkg::*;
#(
    parameter int WORD_W     = 14,
    parameter int ROW_WORDS  = 32,
    parameter int NUM_WORDS  = 2048,
    parameter int BOOT_WORDS = 512,
    parameter int ERASE_CYC  = 40,
    parameter int WRITE_CYC  = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [2:0]                    cmd_op,
    input  logic [$clog2(NUM_WORDS)-1:0]  cmd_addr,
    input  logic [WORD_W-1:0]             cmd_wdata,
    input  logic                          prg_valid,
    input  logic [1:0]                    prg_op,
    input  logic [$clog2(NUM_WORDS)-1:0]  prg_addr,
    input  logic [WORD_W-1:0]             prg_wdata,
    output logic                          busy,
    output logic                          done,
    output logic                          err,
    output logic [WORD_W-1:0]             rdata
);
    localparam int AW   = $clog2(NUM_WORDS);
    localparam int CW   = $clog2(ROW_WORDS);
    localparam int RW   = AW - CW;
    localparam int MAXC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic                             busy;
        job_e                             job;
        logic [AW-1:0]                    tgt;
        logic [WORD_W-1:0]                pdata;
        logic [AW-1:0]                    addr;
        logic [ROW_WORDS-1:0][WORD_W-1:0] latch;
        logic [WORD_W-1:0]                rdata;
        logic                             done;
        logic                             err;
        logic [1:0]                       wrt;
        logic                             cp;
    } st_t;

    st_t st_q, st_d;

    logic              tmr_start, tmr_expired, tmr_run;
    logic [TW-1:0]     tmr_len;
    logic              self_blocked;
    logic [AW-1:0]     row_base;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              a_bulk, a_row_erase, a_row_prog, a_word_prog;
    logic [1:0]        wrt_now;
    logic              cp_now;

    assign row_base = {st_q.addr[AW-1:CW], {CW{1'b0}}};
    assign rd_addr  = prg_valid ? prg_addr : st_q.addr;

    flash_wp_check #(
        .AW(AW), .NUM_WORDS(NUM_WORDS), .BOOT_WORDS(BOOT_WORDS)
    ) u_wp (
        .wrt(st_q.wrt), .addr(row_base), .blocked(self_blocked)
    );

    flash_op_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len),
        .run(tmr_run), .expired(tmr_expired)
    );

    flash_array #(
        .WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .NUM_WORDS(NUM_WORDS)
    ) u_arr (
        .clk(clk), .rd_addr(rd_addr), .rd_data(rd_word),
        .bulk_erase(a_bulk), .row_erase(a_row_erase), .row_prog(a_row_prog),
        .row_sel(st_q.tgt[AW-1:CW]), .row_data(st_q.latch),
        .word_prog(a_word_prog), .word_addr(st_q.tgt), .word_data(st_q.pdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        tmr_start   = 1'b0;
        tmr_len     = '0;
        a_bulk      = 1'b0;
        a_row_erase = 1'b0;
        a_row_prog  = 1'b0;
        a_word_prog = 1'b0;

        if (st_q.busy) begin
            if (tmr_expired) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                unique case (st_q.job)
                    J_ERASE_ROW: a_row_erase = 1'b1;
                    J_WRITE_ROW: begin
                        a_row_prog = 1'b1;
                        st_d.latch = '1;
                    end
                    J_PROG_WORD: a_word_prog = 1'b1;
                    J_BULK: begin
                        a_bulk    = 1'b1;
                        st_d.wrt  = 2'b11;
                        st_d.cp   = 1'b0;
                    end
                endcase
            end
        end else if (prg_valid) begin
            st_d.done = 1'b1;
            st_d.err  = 1'b0;
            unique case (prog_op_e'(prg_op))
                P_READ: begin
                    if (st_q.cp) st_d.err   = 1'b1;
                    else         st_d.rdata = rd_word;
                end
                P_WRITE: begin
                    if (st_q.cp) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.done  = 1'b0;
                        st_d.busy  = 1'b1;
                        st_d.job   = J_PROG_WORD;
                        st_d.tgt   = prg_addr;
                        st_d.pdata = prg_wdata;
                        tmr_start  = 1'b1;
                        tmr_len    = TW'(WRITE_CYC);
                    end
                end
                P_BULK: begin
                    st_d.done = 1'b0;
                    st_d.busy = 1'b1;
                    st_d.job  = J_BULK;
                    tmr_start = 1'b1;
                    tmr_len   = TW'(ERASE_CYC);
                end
                P_CFG: begin
                    if (st_q.cp) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.wrt = st_q.wrt & prg_wdata[1:0];
                        st_d.cp  = ~prg_wdata[2];
                    end
                end
            endcase
        end else if (cmd_valid) begin
            st_d.done = 1'b1;
            st_d.err  = 1'b0;
            unique case (host_op_e'(cmd_op))
                H_SETADDR: st_d.addr  = cmd_addr;
                H_READ:    st_d.rdata = rd_word;
                H_LOAD: begin
                    st_d.latch[st_q.addr[CW-1:0]] = cmd_wdata;
                    st_d.addr[CW-1:0] = st_q.addr[CW-1:0] + CW'(1);
                end
                H_ERASE: begin
                    if (self_blocked) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.done = 1'b0;
                        st_d.busy = 1'b1;
                        st_d.job  = J_ERASE_ROW;
                        st_d.tgt  = row_base;
                        tmr_start = 1'b1;
                        tmr_len   = TW'(ERASE_CYC);
                    end
                end
                H_WRITE: begin
                    if (self_blocked) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.done = 1'b0;
                        st_d.busy = 1'b1;
                        st_d.job  = J_WRITE_ROW;
                        st_d.tgt  = row_base;
                        tmr_start = 1'b1;
                        tmr_len   = TW'(WRITE_CYC);
                    end
                end
                default: st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.job   <= J_ERASE_ROW;
            st_q.latch <= '1;
            st_q.wrt   <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign err     = st_q.err;
    assign rdata   = st_q.rdata;
    assign wrt_now = st_q.wrt;
    assign cp_now  = st_q.cp;

    if (RW < 1) begin : g_bad_geometry
        initial $error("array must hold more than one row");
    end
endmodule

// File: rtl/flash_row_ctrl_chk.sv
module flash_row_ctrl_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [2:0]   cmd_op,
    input logic         prg_valid,
    input logic [1:0]   prg_op,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [W-1:0] rdata,
    input logic [1:0]   wrt_now,
    input logic         cp_now,
    input logic         tmr_run
);
    logic idle_host, idle_prg;
    assign idle_host = !busy && !prg_valid && cmd_valid;
    assign idle_prg  = !busy && prg_valid;

    // R6
    busy_matches_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == tmr_run);

    // R6
    done_at_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    rdata_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rdata));

    // R2
    host_read_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_host && cmd_op == 3'd1) |=> (done && !busy && !err));

    // R9
    self_bulk_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_host && cmd_op == 3'd5) |=> (err && done && !busy));

    // R8
    full_wp_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_host && (cmd_op == 3'd3 || cmd_op == 3'd4) && wrt_now == 2'b00)
        |=> (err && done && !busy));

    // R10
    cp_read_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_prg && prg_op == 2'd0 && cp_now) |=> (err && $stable(rdata)));

    // R11
    bulk_always_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_prg && prg_op == 2'd2) |=> (busy && !err));

    // R13
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
endmodule

bind flash_row_ctrl flash_row_ctrl_chk #(.W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .prg_valid(prg_valid), .prg_op(prg_op), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .wrt_now(wrt_now), .cp_now(cp_now),
    .tmr_run(tmr_run)
);

// File: tb/sim_flash_row_ctrl.sv
module sim_flash_row_ctrl;
    localparam int NW   = 256;
    localparam int RWD  = 32;
    localparam int BOOT = 64;
    localparam int EC   = 5;
    localparam int WC   = 7;
    localparam int AW   = 8;
    localparam int NROW = NW / RWD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [13:0]   cmd_wdata = '0;
    logic          prg_valid = 1'b0;
    logic [1:0]    prg_op = '0;
    logic [AW-1:0] prg_addr = '0;
    logic [13:0]   prg_wdata = '0;
    logic          busy, done, err;
    logic [13:0]   rdata;

    always #2 clk = ~clk;

    flash_row_ctrl #(
        .WORD_W(14), .ROW_WORDS(RWD), .NUM_WORDS(NW), .BOOT_WORDS(BOOT),
        .ERASE_CYC(EC), .WRITE_CYC(WC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .prg_valid(prg_valid),
        .prg_op(prg_op), .prg_addr(prg_addr), .prg_wdata(prg_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [13:0] model [NW];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic host(input int op, input int a, input int d, output int cyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = AW'(a); cmd_wdata = 14'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(cyc);
    endtask

    task automatic prg(input int op, input int a, input int d, output int cyc);
        @(negedge clk);
        prg_valid = 1'b1; prg_op = 2'(op); prg_addr = AW'(a); prg_wdata = 14'(d);
        @(negedge clk);
        prg_valid = 1'b0;
        wait_done(cyc);
    endtask

    task automatic host_read(input int a, output logic [13:0] v);
        int c;
        host(0, a, 0, c);
        host(1, 0, 0, c);
        v = rdata;
    endtask

    task automatic verify_host(input string req);
        logic [13:0] v;
        for (int a = 0; a < NW; a++) begin
            host_read(a, v);
            chk(v == model[a], req, v, model[a]);
        end
    endtask

    task automatic verify_prg(input string req);
        int c;
        for (int a = 0; a < NW; a++) begin
            prg(0, a, 0, c);
            chk(rdata == model[a] && !err, req, rdata, model[a]);
        end
    endtask

    task automatic model_fill_ones();
        for (int a = 0; a < NW; a++) model[a] = 14'h3FFF;
    endtask

    function automatic logic [13:0] pat(input int r, input int i, input int s);
        return 14'((r * 97 + i * 331 + s * 1237 + 5) % 16384);
    endfunction

    int lim_tab [4];

    initial begin
        int c;
        logic [13:0] v, keep;
        lim_tab[0] = NW; lim_tab[1] = NW / 2; lim_tab[2] = BOOT; lim_tab[3] = 0;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && err == 0, "R1", {busy, done, err}, 0);
        chk(rdata == 14'h0, "R1", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R6 bulk erase timing and contents
        prg(2, 0, 0, c);
        chk(c == EC && !busy, "R6", c, EC);
        model_fill_ones();
        verify_prg("R11");

        // R4 / R3 / R6 program every row with a pattern
        for (int r = 0; r < NROW; r++) begin
            host(0, r * RWD, 0, c);
            for (int i = 0; i < RWD; i++) begin
                host(2, 0, pat(r, i, 1), c);
                chk(c == 0 && !busy, "R3", c, 0);
            end
            host(4, 0, 0, c);
            chk(c == WC && !err, "R6", c, WC);
            for (int i = 0; i < RWD; i++) model[r * RWD + i] &= pat(r, i, 1);
        end
        verify_host("R4");

        // R4 second program without erase, partial latch load
        host(0, 3 * RWD + 10, 0, c);
        for (int i = 10; i < 15; i++) begin
            host(2, 0, pat(3, i, 2), c);
            model[3 * RWD + i] &= pat(3, i, 2);
        end
        host(4, 0, 0, c);
        verify_host("R4");

        // R5 row erase
        host(0, 2 * RWD + 7, 0, c);
        host(3, 0, 0, c);
        chk(c == EC && !err, "R6", c, EC);
        for (int i = 0; i < RWD; i++) model[2 * RWD + i] = 14'h3FFF;
        verify_host("R5");

        // R3 latch index wraps within the row
        host(0, 2 * RWD + 30, 0, c);
        for (int k = 0; k < 4; k++) host(2, 0, 14'h0100 + k, c);
        host(4, 0, 0, c);
        model[2 * RWD + 30] = 14'h0100;
        model[2 * RWD + 31] = 14'h0101;
        model[2 * RWD + 0]  = 14'h0102;
        model[2 * RWD + 1]  = 14'h0103;
        verify_host("R3");

        // R9 self bulk erase and unused host ops refused
        for (int op = 5; op < 8; op++) begin
            host(op, 0, 0, c);
            chk(err == 1 && c == 0, "R9", err, 1);
        end
        verify_host("R9");
        // R13 err cleared by a good command
        host(1, 0, 0, c);
        chk(err == 0, "R13", err, 0);

        // R7 commands during busy are ignored
        host(0, 5 * RWD, 0, c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1, "R7", busy, 1);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = 8'h11;
        prg_valid = 1'b1; prg_op = 2'd1; prg_addr = 8'h00; prg_wdata = 14'h0;
        @(negedge clk);
        cmd_valid = 1'b0; prg_valid = 1'b0;
        wait_done(c);
        for (int i = 0; i < RWD; i++) model[5 * RWD + i] = 14'h3FFF;
        host(1, 0, 0, c);
        chk(rdata == model[5 * RWD], "R7", rdata, model[5 * RWD]);
        host_read(0, v);
        chk(v == model[0], "R7", v, model[0]);

        // R12 programmer wins when both ports are valid
        host(0, 7 * RWD + 3, 0, c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = 8'h00;
        prg_valid = 1'b1; prg_op = 2'd0; prg_addr = 8'd9;
        @(negedge clk);
        cmd_valid = 1'b0; prg_valid = 1'b0;
        chk(rdata == model[9], "R12", rdata, model[9]);
        host(1, 0, 0, c);
        chk(rdata == model[7 * RWD + 3], "R12", rdata, model[7 * RWD + 3]);

        // R8 every write-protect encoding over every row
        for (int enc = 3; enc >= 0; enc--) begin
            prg(2, 0, 0, c);
            model_fill_ones();
            prg(3, 0, {1'b1, 2'(enc)}, c);
            chk(!err, "R12", err, 0);
            for (int r = 0; r < NROW; r++) begin
                bit prot;
                prot = (r * RWD) < lim_tab[enc];
                host(0, r * RWD, 0, c);
                for (int i = 0; i < RWD; i++) host(2, 0, pat(r, i, enc), c);
                host(4, 0, 0, c);
                chk(err == prot, "R8", err, prot);
                if (!prot) for (int i = 0; i < RWD; i++) model[r * RWD + i] &= pat(r, i, enc);
            end
            prg(1, 1, 14'h1234, c);
            chk(!err && c == WC, "R8", err, 0);
            model[1] &= 14'h1234;
            verify_prg("R8");
        end

        // R11 bulk restores write-protect to none (was 00)
        prg(2, 0, 0, c);
        model_fill_ones();
        host(0, 0, 0, c);
        for (int i = 0; i < RWD; i++) host(2, 0, pat(0, i, 9), c);
        host(4, 0, 0, c);
        chk(!err, "R11", err, 0);
        for (int i = 0; i < RWD; i++) model[i] &= pat(0, i, 9);

        // R10 code protection
        prg(0, 3, 0, c);
        keep = rdata;
        prg(3, 0, 14'h3, c);
        chk(!err, "R12", err, 0);
        prg(0, 4, 0, c);
        chk(err == 1 && rdata == keep, "R10", rdata, keep);
        prg(1, 1, 14'h0, c);
        chk(err == 1 && c == 0, "R10", err, 1);
        prg(3, 0, 14'h7, c);
        chk(err == 1, "R10", err, 1);
        verify_host("R10");
        host(0, 0, 0, c);
        host(3, 0, 0, c);
        chk(!err && c == EC, "R10", err, 0);
        for (int i = 0; i < RWD; i++) model[i] = 14'h3FFF;
        verify_host("R10");
        prg(2, 0, 0, c);
        model_fill_ones();
        prg(0, 4, 0, c);
        chk(!err && rdata == 14'h3FFF, "R11", rdata, 14'h3FFF);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule